// File: doc/BRIEF.md
# Direct Digital Synthesis FM Modulator

This block turns an 8-bit amplitude sample into a frequency-modulated sine wave by direct digital synthesis. An external converter digitises a Gaussian-shaped baseband signal. The block gives that converter its sample clock, a divide-by-20 of the system clock, and registers each code on the clock's rising edge. Each held code selects a signed frequency offset from a linear 256-step map. The offset is added to one of four carrier centre words, so the peak deviation is ±2 kHz. At an 8 kHz symbol rate that is a modulation index of 0.5.

The resulting 40-bit tuning word is added into a 40-bit phase register on every system clock. The ten top phase bits address a full-period sine table whose 10-bit offset-binary samples feed a DAC. When the modulation enable is low, the converter code is not used and the output is a plain carrier at the selected centre. With a 20 MHz system clock, one tuning-word step is 20 MHz / 2^40 (about 18.2 µHz).

Top module: `fm_dds_modulator`

## Requirements
- R1: The 40-bit phase register adds the current tuning word on every rising clock edge, modulo 2^40. A synchronous active-low reset clears it to zero.
- R2: `dac_out` is registered. One clock after the phase register holds P, `dac_out` equals table entry P[39:30]. Entry i is 512 + 511·sin(2π·i/1024), offset binary, within ±2 LSB.
- R3: While reset is applied, `dac_out` reads 512 and `adc_clk` reads 0.
- R4: `adc_clk` rises on the first clock edge that sees reset released. It then repeats with a period of 20 system clocks, high for 10 and low for 10.
- R5: `adc_data` is captured only on the clock edge where `adc_clk` rises, and the captured value is held until the next such edge. Changes at any other time have no effect on the output.
- R6: `car_sel` picks the centre word floor(f·2^40/20e6) mod 2^40 for f = 20 kHz (0), 200 kHz (1), 2 MHz (2) or 20 MHz (3). This gives 10995116277 for code 1 and 0 for code 3, so with enable low and code 3 the output stands still.
- R7: With `mod_en` low the tuning word is the centre word alone, whatever the held sample.
- R8: With `mod_en` high the tuning word is the centre word plus round((k·4000/255 − 2000)·2^40/20e6), modulo 2^40, for held code k. At 200 kHz, code 0 gives 10885165114 and code 255 gives 11105067440.
- R9: For held codes below 128 the modulated word lies below the centre, and for codes 128 and above it lies above the centre.
- R10: A change of `car_sel`, `mod_en` or the held sample acts on the phase register at the very next clock edge, with no extra pipeline stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (20 MHz nominal) |
| rst_n | input | 1 | Synchronous active-low reset |
| adc_data | input | 8 | Amplitude code from the external converter |
| adc_clk | output | 1 | Converter sample clock, system clock divided by 20 |
| car_sel | input | 2 | Carrier centre select |
| mod_en | input | 1 | 1: modulate with the held sample, 0: plain carrier |
| dac_out | output | 10 | Offset-binary sine sample for the DAC |

## Verification
The phase register is internal, so any fault in it or in the tuning word shows only as `dac_out` drifting from the expected sine sequence. A wrong centre word or a wrong enable path moves the table index by about ten entries per cycle at 200 kHz, which breaks the expected samples within one or two clocks. A wrong offset or a sample captured at the wrong edge moves the index by only about 0.1 entry per cycle. It becomes visible only after tens of cycles, so each scenario runs long enough for such slow drift to build up past the tolerance. A fault in the divider shows directly at `adc_clk` in the first cycle it occurs.

// File: rtl/fm_dds_pkg.sv
// Package: fm_dds_pkg
// Shared carrier-select type and the elaboration-time functions that
// build the tuning words and the sine table. Assumes widths up to 40-bit
// phase and clock rates small enough that products fit a 64-bit longint.
package fm_dds_pkg;

    typedef enum logic [1:0] {
        CAR_LOW  = 2'd0,
        CAR_MID  = 2'd1,
        CAR_HIGH = 2'd2,
        CAR_TOP  = 2'd3
    } carrier_e;

    // Centre tuning word: floor(f * 2^acc_w / clk) mod 2^acc_w, split to avoid overflow.
    function automatic longint centre_word(longint f_hz, longint clk_hz, int acc_w);
        longint full;
        longint q;
        longint r;
        full = longint'(1) << acc_w;
        q    = full / clk_hz;
        r    = full % clk_hz;
        return (f_hz * q + (f_hz * r) / clk_hz) % full;
    endfunction

    // Signed offset for code k: round((k*2dev/(N-1) - dev) * 2^acc_w / clk).
    function automatic longint offset_word(int code, int adc_w, longint dev_hz,
                                           longint clk_hz, int acc_w);
        longint nm1;
        longint num;
        longint den;
        nm1 = (longint'(1) << adc_w) - longint'(1);
        num = (longint'(code) * longint'(2) * dev_hz - dev_hz * nm1) * (longint'(1) << acc_w);
        den = nm1 * clk_hz;
        if (num >= 0)
            return (num + den / 2) / den;
        else
            return -((-num + den / 2) / den);
    endfunction

    // Offset-binary sine sample from a rational half-wave approximation.
    function automatic int sine_code(int idx, int aw, int dw);
        longint p;
        longint t;
        longint prod;
        longint amp;
        longint mid;
        longint den;
        longint mag;
        p    = longint'(1) << (aw - 1);
        t    = longint'(idx) % p;
        prod = t * (p - t);
        amp  = (longint'(1) << (dw - 1)) - longint'(1);
        mid  = longint'(1) << (dw - 1);
        den  = longint'(5) * p * p - longint'(4) * prod;
        mag  = (longint'(16) * prod * amp + den / 2) / den;
        if (longint'(idx) >= p)
            return int'(mid - mag);
        else
            return int'(mid + mag);
    endfunction

endpackage

// File: rtl/fmd_adc_sampler.sv
// Module: fmd_adc_sampler
// Divides the system clock into the converter sample clock and registers
// the converter code on the edge where that clock rises. Assumes the
// external converter presents stable data at that edge.
module fmd_adc_sampler #(
    parameter int unsigned DIV   = 20,
    parameter int unsigned ADC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ADC_W-1:0] adc_data,
    output logic             adc_clk,
    output logic [ADC_W-1:0] sample
);
    localparam int unsigned    CW   = $clog2(DIV);
    localparam logic [CW-1:0]  LAST = CW'(DIV - 1);
    localparam logic [CW-1:0]  HALF = CW'(DIV / 2);

    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_nx;

    // Next divider count, wrapping after the last state.
    always_comb cnt_nx = (cnt == LAST) ? '0 : cnt + CW'(1);

    // Divider, sample clock and sample hold register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= LAST;
            adc_clk <= 1'b0;
            sample  <= '0;
        end else begin
            cnt     <= cnt_nx;
            adc_clk <= (cnt_nx < HALF);
            if (cnt == LAST)
                sample <= adc_data;
        end
    end

    a_r4_rise_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_clk) |-> cnt == '0);

    a_r5_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(adc_clk) |-> $stable(sample));

endmodule

// File: rtl/fmd_tuning_map.sv
// Module: fmd_tuning_map
// Forms the tuning word as the selected carrier centre plus, when
// modulation is enabled, a signed offset looked up from the held code.
// Purely combinational; all tables are computed at elaboration.
module fmd_tuning_map
    import fm_dds_pkg::*;
#(
    parameter longint CLK_HZ  = 20_000_000,
    parameter longint CAR0_HZ = 20_000,
    parameter longint CAR1_HZ = 200_000,
    parameter longint CAR2_HZ = 2_000_000,
    parameter longint CAR3_HZ = 20_000_000,
    parameter longint DEV_HZ  = 2_000,
    parameter int     ACC_W   = 40,
    parameter int     ADC_W   = 8
) (
    input  logic [1:0]       car_sel,
    input  logic             mod_en,
    input  logic [ADC_W-1:0] sample,
    output logic [ACC_W-1:0] word
);
    localparam int NCODES = 1 << ADC_W;
    localparam logic [ACC_W-1:0] C0 = ACC_W'(centre_word(CAR0_HZ, CLK_HZ, ACC_W));
    localparam logic [ACC_W-1:0] C1 = ACC_W'(centre_word(CAR1_HZ, CLK_HZ, ACC_W));
    localparam logic [ACC_W-1:0] C2 = ACC_W'(centre_word(CAR2_HZ, CLK_HZ, ACC_W));
    localparam logic [ACC_W-1:0] C3 = ACC_W'(centre_word(CAR3_HZ, CLK_HZ, ACC_W));

    logic [ACC_W-1:0] ofs_tab [NCODES];
    logic [ACC_W-1:0] centre;
    logic [ACC_W-1:0] offset;

    for (genvar k = 0; k < NCODES; k++) begin : g_ofs
        localparam longint OFS = offset_word(k, ADC_W, DEV_HZ, CLK_HZ, ACC_W);
        assign ofs_tab[k] = ACC_W'(OFS);
    end

    // Carrier centre chosen by the select code.
    always_comb begin
        case (carrier_e'(car_sel))
            CAR_LOW:  centre = C0;
            CAR_MID:  centre = C1;
            CAR_HIGH: centre = C2;
            default:  centre = C3;
        endcase
    end

    // Offset applied only while modulation is enabled.
    always_comb offset = mod_en ? ofs_tab[sample] : '0;

    // Final tuning word, modulo the phase width.
    always_comb word = centre + offset;

endmodule

// File: rtl/fmd_phase_acc.sv
// Module: fmd_phase_acc
// Phase register that adds the tuning word every clock, wrapping modulo
// 2^ACC_W. Assumes the word is valid before each rising edge.
module fmd_phase_acc #(
    parameter int ACC_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] word,
    output logic [ACC_W-1:0] phase
);
    // Accumulate the tuning word; reset clears the phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else
            phase <= phase + word;
    end

    a_r1_cleared_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> phase == '0);

endmodule

// File: rtl/fmd_sine_lut.sv
// Module: fmd_sine_lut
// Full-period sine table with a registered output in offset binary.
// Table contents are computed at elaboration; assumes AW of 12 or less.
module fmd_sine_lut
    import fm_dds_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] dout
);
    localparam int            DEPTH = 1 << AW;
    localparam logic [DW-1:0] MID   = DW'(1 << (DW - 1));

    logic [DW-1:0] rom [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_rom
        localparam int VAL = sine_code(i, AW, DW);
        assign rom[i] = DW'(VAL);
    end

    // Registered table read; reset parks the output at mid-scale.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dout <= MID;
        else
            dout <= rom[addr];
    end

    a_r2_zero_phase_mid: assert property (@(posedge clk) disable iff (!rst_n)
        $past(addr) == '0 |-> dout == MID);

endmodule

// File: rtl/fm_dds_modulator.sv
// Module: fm_dds_modulator
// Top of the FM synthesis core: converter sampling, tuning-word map,
// phase register and sine table. Assumes a single clock domain; the
// converter is clocked from adc_clk and settles before its next rise.
module fm_dds_modulator
    import fm_dds_pkg::*;
#(
    parameter longint CLK_HZ  = 20_000_000,
    parameter longint CAR0_HZ = 20_000,
    parameter longint CAR1_HZ = 200_000,
    parameter longint CAR2_HZ = 2_000_000,
    parameter longint CAR3_HZ = 20_000_000,
    parameter longint DEV_HZ  = 2_000,
    parameter int     ACC_W   = 40,
    parameter int     ADC_W   = 8,
    parameter int     DAC_W   = 10,
    parameter int     LUT_AW  = 10,
    parameter int     ADC_DIV = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ADC_W-1:0] adc_data,
    output logic             adc_clk,
    input  logic [1:0]       car_sel,
    input  logic             mod_en,
    output logic [DAC_W-1:0] dac_out
);
    localparam logic [ADC_W-1:0] HALF_CODE = ADC_W'(1 << (ADC_W - 1));
    localparam logic [ACC_W-1:0] MID_CTR   = ACC_W'(centre_word(CAR1_HZ, CLK_HZ, ACC_W));

    logic [ADC_W-1:0] sample;
    logic [ACC_W-1:0] word;
    logic [ACC_W-1:0] phase;

    fmd_adc_sampler #(
        .DIV   (ADC_DIV),
        .ADC_W (ADC_W)
    ) u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .adc_data (adc_data),
        .adc_clk  (adc_clk),
        .sample   (sample)
    );

    fmd_tuning_map #(
        .CLK_HZ  (CLK_HZ),
        .CAR0_HZ (CAR0_HZ),
        .CAR1_HZ (CAR1_HZ),
        .CAR2_HZ (CAR2_HZ),
        .CAR3_HZ (CAR3_HZ),
        .DEV_HZ  (DEV_HZ),
        .ACC_W   (ACC_W),
        .ADC_W   (ADC_W)
    ) u_map (
        .car_sel (car_sel),
        .mod_en  (mod_en),
        .sample  (sample),
        .word    (word)
    );

    fmd_phase_acc #(
        .ACC_W (ACC_W)
    ) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .word  (word),
        .phase (phase)
    );

    fmd_sine_lut #(
        .AW (LUT_AW),
        .DW (DAC_W)
    ) u_lut (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (phase[ACC_W-1 -: LUT_AW]),
        .dout  (dac_out)
    );

    a_r9_below_centre: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_en && car_sel == 2'd1 && sample < HALF_CODE) |-> word < MID_CTR);

    a_r9_above_centre: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_en && car_sel == 2'd1 && sample >= HALF_CODE) |-> word > MID_CTR);

    a_r7_plain_carrier: assert property (@(posedge clk) disable iff (!rst_n)
        (!mod_en && car_sel == 2'd1) |-> word == MID_CTR);

endmodule

// File: tb/test_fm_dds_modulator.sv
// Directed bench: an independent cycle model built from the requirements
// predicts dac_out and adc_clk; each scenario task checks its own run.
module test_fm_dds_modulator;

    localparam real TWO40 = 1099511627776.0;
    localparam real PI    = 3.14159265358979323846;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] adc_data;
    logic       adc_clk;
    logic [1:0] car_sel;
    logic       mod_en;
    logic [9:0] dac_out;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    // Model state
    logic [39:0] m_acc;
    logic [7:0]  m_held;
    int          m_cnt;
    int          m_dac_exp;
    logic        m_adc_exp;

    // Segment bookkeeping
    int seg_bad;
    int seg_act;
    int seg_exp;

    always #2 clk = ~clk;

    fm_dds_modulator i_fm_dds_modulator (
        .clk      (clk),
        .rst_n    (rst_n),
        .adc_data (adc_data),
        .adc_clk  (adc_clk),
        .car_sel  (car_sel),
        .mod_en   (mod_en),
        .dac_out  (dac_out)
    );

    function automatic logic [39:0] m_word(logic [1:0] sel, logic en, logic [7:0] k);
        real    f;
        longint ci;
        longint oi;
        case (sel)
            2'd0:    f = 0.001;
            2'd1:    f = 0.01;
            2'd2:    f = 0.1;
            default: f = 1.0;
        endcase
        ci = longint'($floor(f * TWO40));
        oi = 0;
        if (en)
            oi = longint'((real'(int'(k)) * 4000.0 / 255.0 - 2000.0) * TWO40 / 20.0e6);
        return 40'(ci + oi);
    endfunction

    function automatic int m_sine(int i);
        return 512 + int'(511.0 * $sin(2.0 * PI * real'(i) / 1024.0));
    endfunction

    // Reference model of the requirements, advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_acc     = '0;
            m_cnt     = 19;
            m_held    = '0;
            m_dac_exp = 512;
            m_adc_exp = 1'b0;
        end else begin
            m_dac_exp = m_sine(int'(m_acc[39:30]));
            m_acc     = m_acc + m_word(car_sel, mod_en, m_held);
            if (m_cnt == 19) begin
                m_cnt  = 0;
                m_held = adc_data;
            end else begin
                m_cnt = m_cnt + 1;
            end
            m_adc_exp = (m_cnt < 10);
        end
    end

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cycles = cycles + 1;
        if (cycles == 150000) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: act=%0d cycles exp=<150000", cycles);
            summary();
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic seg_begin();
        seg_bad = 0;
        seg_act = 0;
        seg_exp = 0;
    endtask

    // One cycle: wait for the falling edge and compare both outputs.
    task automatic step();
        int diff;
        @(negedge clk);
        diff = int'(dac_out) - m_dac_exp;
        if (diff > 2 || diff < -2) begin
            if (seg_bad == 0) begin
                seg_act = int'(dac_out);
                seg_exp = m_dac_exp;
            end
            seg_bad = seg_bad + 1;
        end
        if (adc_clk !== m_adc_exp) begin
            if (seg_bad == 0) begin
                seg_act = 2000 + int'(adc_clk);
                seg_exp = 2000 + int'(m_adc_exp);
            end
            seg_bad = seg_bad + 1;
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic seg_end(input string req);
        check(seg_bad == 0, req, seg_act, seg_exp);
    endtask

    // R3 and R4: outputs under reset, then the divider pattern after release.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(dac_out == 10'd512, "R3 dac mid-scale in reset", dac_out, 512);
        check(adc_clk == 1'b0, "R3 adc_clk low in reset", adc_clk, 0);
        rst_n = 1'b1;
        seg_begin();
        run(65);
        seg_end("R4 adc_clk divide-by-20 pattern");
    endtask

    // R6 and R7: each carrier unmodulated while the converter code moves.
    task automatic t_idle();
        for (int s = 0; s < 3; s++) begin
            car_sel = 2'(s);
            mod_en  = 1'b0;
            seg_begin();
            for (int j = 0; j < 8; j++) begin
                adc_data = 8'(j * 37);
                run(20);
            end
            seg_end(s == 1 ? "R7 plain carrier ignores adc" : "R6 carrier select");
        end
    endtask

    // R6: the top carrier folds to a zero word, so the output stands still.
    task automatic t_top();
        int held_val;
        car_sel = 2'd3;
        mod_en  = 1'b0;
        adc_data = 8'd200;
        seg_begin();
        run(4);
        held_val = int'(dac_out);
        run(60);
        seg_end("R6 top carrier model");
        check(int'(dac_out) == held_val, "R6 top carrier output static", dac_out, held_val);
    endtask

    // R8: extreme and middle codes at the 200 kHz carrier.
    task automatic t_extremes();
        car_sel = 2'd1;
        mod_en  = 1'b1;
        adc_data = 8'd0;
        seg_begin();
        run(300);
        seg_end("R8 code 0 low deviation");
        adc_data = 8'd255;
        seg_begin();
        run(300);
        seg_end("R8 code 255 high deviation");
        adc_data = 8'd128;
        seg_begin();
        run(300);
        seg_end("R8 code 128 near centre");
    endtask

    // R9 and R2: ramp through many codes at two carriers.
    task automatic t_sweep();
        mod_en = 1'b1;
        car_sel = 2'd1;
        seg_begin();
        for (int c = 0; c < 256; c += 9) begin
            adc_data = 8'(c);
            run(20);
        end
        seg_end("R9 code ramp at 200 kHz");
        car_sel = 2'd0;
        seg_begin();
        for (int c = 255; c >= 0; c -= 11) begin
            adc_data = 8'(c);
            run(20);
        end
        seg_end("R2 sine samples at 20 kHz");
    endtask

    // R5: a pulse on adc_data between capture edges must not be taken.
    task automatic t_glitch();
        car_sel  = 2'd1;
        mod_en   = 1'b1;
        adc_data = 8'd0;
        seg_begin();
        run(5);
        for (int g = 0; g < 25 && m_cnt != 2; g++) step();
        adc_data = 8'd255;
        for (int g = 0; g < 25 && m_cnt != 12; g++) step();
        adc_data = 8'd0;
        run(200);
        seg_end("R5 adc change between captures ignored");
    endtask

    // R10: select and enable changes at odd spacings act on the next edge.
    task automatic t_switch();
        adc_data = 8'd60;
        seg_begin();
        for (int j = 0; j < 24; j++) begin
            car_sel = 2'(j % 3);
            mod_en  = 1'(j % 2);
            run(13);
        end
        seg_end("R10 immediate select and enable");
    endtask

    // R1: fast wrap at 2 MHz, then a mid-run reset restarts from zero phase.
    task automatic t_wrap_reset();
        car_sel  = 2'd2;
        mod_en   = 1'b1;
        adc_data = 8'd230;
        seg_begin();
        run(300);
        seg_end("R1 phase wraps modulo 2^40");
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(dac_out == 10'd512, "R3 dac mid-scale on mid-run reset", dac_out, 512);
        rst_n = 1'b1;
        seg_begin();
        run(200);
        seg_end("R1 phase cleared by reset");
    endtask

    initial begin
        rst_n    = 1'b0;
        adc_data = 8'd0;
        car_sel  = 2'd1;
        mod_en   = 1'b0;
        t_reset();
        t_idle();
        t_top();
        t_extremes();
        t_sweep();
        t_glitch();
        t_switch();
        t_wrap_reset();
        summary();
        $finish;
    end

endmodule